// File: doc/BRIEF.md
# Cascadable Eight-Line Priority Interrupt Controller

This block collects eight interrupt request lines and decides which one the processor serves next. A host reaches it through a byte-wide port with two addresses: offset 0 takes command bytes and offset 1 takes data bytes. After a fixed initialisation sequence, the block holds edge-triggered requests in a pending register and filters them through a software mask. It uses fixed priority (line 0 highest) to pick a winner and raises `int_out`. On an acknowledge it hands back a vector equal to a programmed base plus the line number, and it records the line as in service until the software issues an end-of-interrupt for that line.

Two copies can be chained. The master is built with `IS_SLAVE = 0`, and one or more of its lines are declared as carrying a subordinate controller. The slave is built with `IS_SLAVE = 1` and is given an identity number. Its `int_out` drives one master line, and the master's cascade code and strobe outputs feed the slave's cascade inputs. When the master acknowledges a cascade line, it marks that line in service and stays silent on the vector. The slave whose identity matches supplies its own vector in the same cycle. Software must therefore keep the cascade line unmasked on the master and must end a slave interrupt with one end-of-interrupt to the slave and one for the cascade line to the master.

Special mask mode is selectable. In that mode the in-service bits no longer hold back other lines, and only the mask blocks a request.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask reads 0xFF and `int_out` is low. A command byte with bit 4 set (0x11) clears the pending register, the in-service register and the mask to 0. It also turns special mask mode off and selects the pending register for command-port reads. The next three data-port writes are then taken, in order, as the vector base, the cascade word and the mode word.
- R2: Once initialisation is complete, a data-port write loads the 8-bit mask (bit n = 1 masks line n), and a data-port read returns it. A masked request stays pending but cannot raise `int_out`.
- R3: When `inta` is high for one cycle, the lowest-numbered eligible line is moved from pending to in-service. On the next cycle `vec_valid` is high for one cycle with `vec_out` = base + line.
- R4: Command byte 0x60+n (bits 7:5 = 011, bits 4:3 = 00) clears in-service bit n and leaves every other in-service bit unchanged.
- R5: Command byte 0x0A makes command-port reads return the pending register. Command byte 0x0B makes them return the in-service register. The selection holds until it is changed.
- R6: On the master, the cascade word is a bit mask of the lines that carry slaves. An acknowledge of such a line sets its in-service bit, gives no vector, and drives `cas_code_out` = line with `cas_go_out` high. A slave whose cascade word (its identity, low 3 bits) matches `cas_code_in` while `cas_go_in` is high performs the acknowledge and gives its own vector.
- R7: With special mask mode off, a line is blocked while any in-service bit at its own or a lower line number is set.
- R8: Command byte 0x68 (bits 6:5 = 11, bit 3 = 1) turns special mask mode on, and 0x48 turns it off. While it is on, only masked lines are blocked.
- R9: A request is recorded only on a rising edge of its input. A line held high after being served does not request again.
- R10: `int_out` is high exactly while at least one eligible request exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Host address: 0 command, 1 data |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Host read byte (combinational on `addr`) |
| irq_in | input | 8 | Interrupt request lines |
| inta | input | 1 | Acknowledge strobe |
| cas_code_in | input | 3 | Cascade line code from master (slave only) |
| cas_go_in | input | 1 | Cascade acknowledge strobe from master (slave only) |
| cas_code_out | output | 3 | Line being acknowledged (master) |
| cas_go_out | output | 1 | Acknowledge is routed to a slave (master) |
| int_out | output | 1 | Interrupt request to processor or master |
| vec_out | output | 8 | Vector of the last acknowledge |
| vec_valid | output | 1 | One-cycle pulse qualifying `vec_out` |

## Verification
The in-line assertions check, on every cycle, the invariants that can be stated locally: the effect of the initialisation command on mask and mode, that pending bits appear only after an input edge, that an acknowledge sets and an end-of-interrupt clears the named in-service bit, that `int_out` never rises without an unmasked pending bit, and that a vector is only presented after an acknowledge. Arbitration order, vector arithmetic and nesting depend on sequences of requests and acknowledges over several cycles, so the bench scenarios demonstrate them. The same holds for special mask mode, read selection and the master-to-slave hand-off with its two end-of-interrupts.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_LINES = 8;
  localparam int LINE_W  = $clog2(N_LINES);

  // command byte bits 7:5 for a specific end-of-interrupt
  localparam logic [2:0] EOI_SPEC = 3'b011;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_st_t;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [N_LINES-1:0] mask_q,
  output logic [BYTE_W-1:0] base_q,
  output logic [BYTE_W-1:0] casw_q,
  output logic              smm_q,
  output logic              rd_isr_q,
  output logic              init_clr,
  output logic              eoi_en,
  output logic [LINE_W-1:0] eoi_line
);
  init_st_t          st_q, st_d;
  logic [N_LINES-1:0] mask_d;
  logic [BYTE_W-1:0] base_d, casw_d;
  logic              smm_d, rd_isr_d;
  logic              cmd_wr, dat_wr, ctl_wr, cfg_en;

  always_comb begin
    cmd_wr   = wr_en & ~addr;
    dat_wr   = wr_en & addr;
    init_clr = cmd_wr & wr_data[4];
    ctl_wr   = cmd_wr & ~wr_data[4] & wr_data[3];
    eoi_en   = cmd_wr & ~wr_data[4] & ~wr_data[3] & (wr_data[7:5] == EOI_SPEC);
    eoi_line = wr_data[LINE_W-1:0];
    cfg_en   = init_clr | ctl_wr | dat_wr;

    st_d     = st_q;
    mask_d   = mask_q;
    base_d   = base_q;
    casw_d   = casw_q;
    smm_d    = smm_q;
    rd_isr_d = rd_isr_q;

    if (init_clr) begin
      st_d     = ST_BASE;
      mask_d   = '0;
      smm_d    = 1'b0;
      rd_isr_d = 1'b0;
    end else if (ctl_wr) begin
      if (wr_data[6]) smm_d = wr_data[5];
      if (wr_data[1]) rd_isr_d = wr_data[0];
    end else if (dat_wr) begin
      unique case (st_q)
        ST_RUN:  mask_d = wr_data[N_LINES-1:0];
        ST_BASE: begin base_d = wr_data; st_d = ST_CASC; end
        ST_CASC: begin casw_d = wr_data; st_d = ST_MODE; end
        ST_MODE: st_d = ST_RUN;
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      mask_q   <= '1;
      base_q   <= '0;
      casw_q   <= '0;
      smm_q    <= 1'b0;
      rd_isr_q <= 1'b0;
    end else if (cfg_en) begin
      st_q     <= st_d;
      mask_q   <= mask_d;
      base_q   <= base_d;
      casw_q   <= casw_d;
      smm_q    <= smm_d;
      rd_isr_q <= rd_isr_d;
    end
  end

  // R1
  init_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> (mask_q == '0 && !smm_q && !rd_isr_q && st_q == ST_BASE));

  // R1
  mode_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MODE && dat_wr) |=> (st_q == ST_RUN));
endmodule

// File: rtl/pic_req.sv
module pic_req
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_in,
  input  logic               init_clr,
  input  logic [N_LINES-1:0] ack_clr,
  output logic [N_LINES-1:0] irr_q
);
  logic [N_LINES-1:0] prev_q, irr_d, rise;

  always_comb begin
    rise  = lines_in & ~prev_q;
    irr_d = init_clr ? '0 : ((irr_q & ~ack_clr) | rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= lines_in;
      irr_q  <= irr_d;
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_edge_chk
    // R9
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irr_q[i]) |-> $past(lines_in[i] && !prev_q[i]));
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio
  import pic_pkg::*;
(
  input  logic [N_LINES-1:0] irr,
  input  logic [N_LINES-1:0] mask,
  input  logic [N_LINES-1:0] isr,
  input  logic               smm,
  output logic               win_any,
  output logic [LINE_W-1:0]  win_line
);
  logic [N_LINES-1:0] eligible;

  for (genvar i = 0; i < N_LINES; i++) begin : g_elig
    localparam logic [N_LINES-1:0] UPTO = N_LINES'((2 ** (i + 1)) - 1);
    logic held;
    assign held        = ~smm & (|(isr & UPTO));
    assign eligible[i] = irr[i] & ~mask[i] & ~held;
  end

  always_comb begin
    win_any  = |eligible;
    win_line = '0;
    for (int j = N_LINES - 1; j >= 0; j--) begin
      if (eligible[j]) win_line = LINE_W'(j);
    end
  end
endmodule

// File: rtl/pic_isr.sv
module pic_isr
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_clr,
  input  logic               set_en,
  input  logic [LINE_W-1:0]  set_line,
  input  logic               eoi_en,
  input  logic [LINE_W-1:0]  eoi_line,
  output logic [N_LINES-1:0] isr_q
);
  logic [N_LINES-1:0] isr_d, set_vec, clr_vec;
  logic               isr_en;

  always_comb begin
    set_vec = set_en ? (N_LINES'(1) << set_line) : '0;
    clr_vec = eoi_en ? (N_LINES'(1) << eoi_line) : '0;
    isr_en  = init_clr | set_en | eoi_en;
    isr_d   = init_clr ? '0 : ((isr_q | set_vec) & ~clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_q <= '0;
    else if (isr_en) isr_q <= isr_d;
  end

  // R4
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_en |=> !isr_q[$past(eoi_line)]);

  // R3
  ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !init_clr && !(eoi_en && eoi_line == set_line)) |=> isr_q[$past(set_line)]);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import pic_pkg::*;
#(
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [7:0]        irq_in,
  input  logic              inta,
  input  logic [2:0]        cas_code_in,
  input  logic              cas_go_in,
  output logic [2:0]        cas_code_out,
  output logic              cas_go_out,
  output logic              int_out,
  output logic [7:0]        vec_out,
  output logic              vec_valid
);
  logic [N_LINES-1:0] mask_q, irr_q, isr_q, ack_vec;
  logic [BYTE_W-1:0]  base_q, casw_q, vec_q, vec_d;
  logic               smm_q, rd_isr_q, init_clr, eoi_en;
  logic [LINE_W-1:0]  eoi_line, win_line;
  logic               win_any, sel_me, ack_fire, to_slave;
  logic               vv_q, vv_d;

  pic_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .mask_q(mask_q), .base_q(base_q), .casw_q(casw_q), .smm_q(smm_q),
    .rd_isr_q(rd_isr_q), .init_clr(init_clr), .eoi_en(eoi_en), .eoi_line(eoi_line)
  );

  pic_req u_req (
    .clk(clk), .rst_n(rst_n), .lines_in(irq_in), .init_clr(init_clr),
    .ack_clr(ack_vec), .irr_q(irr_q)
  );

  pic_prio u_prio (
    .irr(irr_q), .mask(mask_q), .isr(isr_q), .smm(smm_q),
    .win_any(win_any), .win_line(win_line)
  );

  pic_isr u_isr (
    .clk(clk), .rst_n(rst_n), .init_clr(init_clr), .set_en(ack_fire),
    .set_line(win_line), .eoi_en(eoi_en), .eoi_line(eoi_line), .isr_q(isr_q)
  );

  if (IS_SLAVE) begin : g_sel_slave
    assign sel_me   = inta & cas_go_in & (cas_code_in == casw_q[LINE_W-1:0]);
    assign to_slave = 1'b0;
  end else begin : g_sel_master
    assign sel_me   = inta;
    assign to_slave = casw_q[win_line];
  end

  always_comb begin
    ack_fire     = sel_me & win_any;
    ack_vec      = ack_fire ? (N_LINES'(1) << win_line) : '0;
    cas_go_out   = ack_fire & to_slave;
    cas_code_out = win_line;
    vv_d         = ack_fire & ~to_slave;
    vec_d        = base_q + BYTE_W'(win_line);
    int_out      = win_any;
    rd_data      = addr ? mask_q : (rd_isr_q ? isr_q : irr_q);
    vec_out      = vec_q;
    vec_valid    = vv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vv_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      vv_q <= vv_d;
      if (vv_d) vec_q <= vec_d;
    end
  end

  // R2
  masked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (|(irr_q & ~mask_q)));

  // R3
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta));
endmodule

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;
  logic clk, rst_n;
  logic m_addr, m_we, s_addr, s_we;
  logic [7:0] m_wd, s_wd, m_rd, s_rd, m_lines, s_lines, m_irq;
  logic inta;
  logic [2:0] m_cas_code, s_cas_code_unused;
  logic m_cas_go, s_cas_go_unused;
  logic m_int, s_int, m_vv, s_vv;
  logic [7:0] m_vec, s_vec;
  int checks = 0, fails = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign m_irq = {m_lines[7:3], s_int, m_lines[1:0]};

  prio_intc #(.IS_SLAVE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .addr(m_addr), .wr_en(m_we), .wr_data(m_wd),
    .rd_data(m_rd), .irq_in(m_irq), .inta(inta), .cas_code_in(3'd0),
    .cas_go_in(1'b0), .cas_code_out(m_cas_code), .cas_go_out(m_cas_go),
    .int_out(m_int), .vec_out(m_vec), .vec_valid(m_vv)
  );

  prio_intc #(.IS_SLAVE(1'b1)) u_slave (
    .clk(clk), .rst_n(rst_n), .addr(s_addr), .wr_en(s_we), .wr_data(s_wd),
    .rd_data(s_rd), .irq_in(s_lines), .inta(inta), .cas_code_in(m_cas_code),
    .cas_go_in(m_cas_go), .cas_code_out(s_cas_code_unused),
    .cas_go_out(s_cas_go_unused), .int_out(s_int), .vec_out(s_vec),
    .vec_valid(s_vv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit slv, input bit a, input logic [7:0] d);
    @(negedge clk);
    if (slv) begin s_addr = a; s_wd = d; s_we = 1'b1; end
    else     begin m_addr = a; m_wd = d; m_we = 1'b1; end
    @(negedge clk);
    s_we = 1'b0; m_we = 1'b0;
  endtask

  task automatic rd(input bit slv, input bit a, input logic [7:0] exp, input string req);
    if (slv) s_addr = a; else m_addr = a;
    #1;
    chk(req, slv ? s_rd : m_rd, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit slv, input logic [7:0] m);
    @(negedge clk);
    if (slv) s_lines = m; else m_lines = m;
    @(negedge clk);
    if (slv) s_lines = '0; else m_lines = '0;
    idle(3);
  endtask

  // acknowledge; from_slave selects which instance must present the vector
  task automatic ack(input bit from_slave, input logic [7:0] exp, input string req);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    #1;
    if (from_slave) begin
      chk({req, " master silent"}, m_vv, 1'b0);
      chk({req, " slave valid"}, s_vv, 1'b1);
      chk({req, " slave vector"}, s_vec, exp);
    end else begin
      chk({req, " valid"}, m_vv, 1'b1);
      chk({req, " vector"}, m_vec, exp);
    end
    idle(2);
  endtask

  task automatic init_pic(input bit slv, input logic [7:0] base, input logic [7:0] cw);
    wr(slv, 1'b0, 8'h11);
    wr(slv, 1'b1, base);
    wr(slv, 1'b1, cw);
    wr(slv, 1'b1, 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; inta = 1'b0;
    m_addr = 1'b0; m_we = 1'b0; m_wd = '0; m_lines = '0;
    s_addr = 1'b0; s_we = 1'b0; s_wd = '0; s_lines = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(1'b0, 1'b1, 8'hFF, "R1 reset mask");
    chk("R1 reset int", m_int, 1'b0);

    init_pic(1'b0, 8'h00, 8'h04);
    init_pic(1'b1, 8'h08, 8'h02);
    rd(1'b0, 1'b1, 8'h00, "R1 init clears mask");
    rd(1'b1, 1'b1, 8'h00, "R1 slave init clears mask");

    // R2 mask and R5 read select
    wr(1'b0, 1'b1, 8'hFF);
    rd(1'b0, 1'b1, 8'hFF, "R2 mask readback");
    pulse(1'b0, 8'h20);
    chk("R2 masked no int", m_int, 1'b0);
    wr(1'b0, 1'b0, 8'h0A);
    rd(1'b0, 1'b0, 8'h20, "R5 pending read");
    wr(1'b0, 1'b1, 8'h00);
    idle(1);
    chk("R10 unmask raises int", m_int, 1'b1);
    ack(1'b0, 8'h05, "R3 line5");
    wr(1'b0, 1'b0, 8'h0B);
    rd(1'b0, 1'b0, 8'h20, "R5 in-service read");
    wr(1'b0, 1'b0, 8'h65);
    rd(1'b0, 1'b0, 8'h00, "R4 eoi 5");

    // R3/R4 sweep over master lines
    for (int n = 0; n < 8; n++) begin
      if (n != 2) begin
        pulse(1'b0, 8'(1 << n));
        chk("R10 int on request", m_int, 1'b1);
        ack(1'b0, 8'(n), "R3 sweep");
        rd(1'b0, 1'b0, 8'(1 << n), "R3 sweep isr");
        wr(1'b0, 1'b0, 8'(8'h60 + n));
        rd(1'b0, 1'b0, 8'h00, "R4 sweep eoi");
        chk("R10 idle int", m_int, 1'b0);
      end
    end

    // R6 cascade sweep over slave lines
    wr(1'b1, 1'b0, 8'h0B);
    for (int k = 0; k < 8; k++) begin
      pulse(1'b1, 8'(1 << k));
      chk("R6 master int via slave", m_int, 1'b1);
      ack(1'b1, 8'(8 + k), "R6 cascade");
      rd(1'b0, 1'b0, 8'h04, "R6 master isr cascade line");
      rd(1'b1, 1'b0, 8'(1 << k), "R6 slave isr");
      wr(1'b1, 1'b0, 8'(8'h60 + k));
      wr(1'b0, 1'b0, 8'h62);
      rd(1'b0, 1'b0, 8'h00, "R6 master eoi");
      rd(1'b1, 1'b0, 8'h00, "R6 slave eoi");
      chk("R6 quiet after eoi", m_int, 1'b0);
    end

    // R7 fixed priority and nesting
    pulse(1'b0, 8'h48);
    ack(1'b0, 8'h03, "R7 lowest wins");
    chk("R7 lower blocked", m_int, 1'b0);
    pulse(1'b0, 8'h02);
    chk("R7 higher nests", m_int, 1'b1);
    ack(1'b0, 8'h01, "R7 nested");
    wr(1'b0, 1'b0, 8'h61);
    idle(1);
    chk("R7 still blocked by 3", m_int, 1'b0);
    wr(1'b0, 1'b0, 8'h63);
    idle(1);
    chk("R7 released", m_int, 1'b1);
    ack(1'b0, 8'h06, "R7 deferred");
    wr(1'b0, 1'b0, 8'h66);
    pulse(1'b0, 8'h10);
    ack(1'b0, 8'h04, "R7 same line");
    pulse(1'b0, 8'h10);
    chk("R7 same line blocked", m_int, 1'b0);
    wr(1'b0, 1'b0, 8'h64);
    idle(1);
    chk("R7 same line released", m_int, 1'b1);
    ack(1'b0, 8'h04, "R7 same line again");
    wr(1'b0, 1'b0, 8'h64);

    // R8 special mask mode
    wr(1'b0, 1'b0, 8'h68);
    pulse(1'b0, 8'h10);
    ack(1'b0, 8'h04, "R8 first");
    pulse(1'b0, 8'h80);
    chk("R8 lower not blocked", m_int, 1'b1);
    ack(1'b0, 8'h07, "R8 lower served");
    rd(1'b0, 1'b0, 8'h90, "R8 two in service");
    wr(1'b0, 1'b0, 8'h67);
    rd(1'b0, 1'b0, 8'h10, "R4 only bit 7 cleared");
    wr(1'b0, 1'b1, 8'h20);
    pulse(1'b0, 8'h20);
    chk("R8 masked still blocked", m_int, 1'b0);
    wr(1'b0, 1'b0, 8'h48);
    wr(1'b0, 1'b1, 8'h00);
    idle(1);
    chk("R8 off restores blocking", m_int, 1'b0);
    wr(1'b0, 1'b0, 8'h64);
    idle(1);
    chk("R7 pending after eoi", m_int, 1'b1);
    ack(1'b0, 8'h05, "R8 pending line");
    wr(1'b0, 1'b0, 8'h65);

    // R9 edge triggered
    @(negedge clk); m_lines = 8'h01;
    idle(3);
    ack(1'b0, 8'h00, "R9 held line");
    wr(1'b0, 1'b0, 8'h60);
    idle(3);
    chk("R9 no re-request while high", m_int, 1'b0);
    @(negedge clk); m_lines = 8'h00;

    // R1 re-initialisation mid service
    pulse(1'b0, 8'h02);
    ack(1'b0, 8'h01, "R1 before reinit");
    init_pic(1'b0, 8'h10, 8'h04);
    rd(1'b0, 1'b1, 8'h00, "R1 reinit mask");
    wr(1'b0, 1'b0, 8'h0B);
    rd(1'b0, 1'b0, 8'h00, "R1 reinit isr");
    pulse(1'b0, 8'h08);
    ack(1'b0, 8'h13, "R3 new base");
    wr(1'b0, 1'b0, 8'h63);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule